// File: doc/BRIEF.md
# Sign-Driven Up/Down Counter with Array Writeback

This block walks a fixed-length array of signed words held in an external memory. It keeps one running count. For each element it reads the word and checks the sign. It then moves the count up by one for a strictly positive word, or down by one for a zero or negative word. The updated count is written back over the element that was just read. When the whole array has been visited, the final count is presented on an output and a completion flag is raised.

The block is made of a controller state machine and a separate datapath. The up/down choice is made by a branch between two distinct controller states. It is not made by computing both results and selecting one. Each element takes six cycles: bound test, read request, sign evaluation, count update, write, index advance. The memory is outside the block. It returns read data in the cycle after a read request.

Top module: `sgn_tally_walker`

## Requirements
- R1: After reset, `done`, `mem_rd` and `mem_wr` are low and `result` is zero.
- R2: A `start` pulse accepted while idle or finished clears the running count and the element index to zero, and latches `base_addr` for the whole run.
- R3: One run issues exactly ELEMS read requests, at addresses `base_addr + i` for i = 0 .. ELEMS-1 in ascending order. The address is computed modulo 2^ADDR_W.
- R4: A fetched word whose sign bit (bit DATA_W-1) is clear and which is nonzero increments the count. A zero word or a word with the sign bit set decrements it. The count wraps modulo 2^DATA_W.
- R5: Each element gets exactly one write cycle (`mem_wr` high for one cycle). Its address equals the address just read, and its data equals the count after that element's update.
- R6: `result` equals the count after the last element. `done` rises after the last write and stays high until the next accepted `start`.
- R7: `mem_rd` and `mem_wr` are never high in the same cycle.
- R8: `done` first reads high 6*ELEMS+1 clock edges after the edge that samples `start`.
- R9: A `start` pulse while a run is in progress has no effect on the run's addresses, written data, result or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a run |
| base_addr | input | ADDR_W | Address of element 0 |
| mem_addr | output | ADDR_W | Memory address for read or write |
| mem_rd | output | 1 | Read request; data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| mem_wdata | output | DATA_W | Write data (updated count) |
| result | output | DATA_W | Running count; final count once `done` |
| done | output | 1 | Run complete, held until the next start |

## Verification
The assertions assume that the memory returns the addressed word in exactly the cycle after a read request. They also assume that `start` is a single-cycle pulse driven away from the clock edge. The bench memory model honours that one-cycle latency and covers only the addresses of the current run. The bench drives `start` at falling edges for one cycle. The one exception is a deliberate extra pulse in the middle of a run, which the design must ignore. Base addresses are chosen so that the array may straddle the top of the address space. This exercises the modular address arithmetic without touching any word outside the array.

// File: rtl/sgn_tally_pkg.sv
package sgn_tally_pkg;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_CMP  = 4'd1,
    ST_RD   = 4'd2,
    ST_SIGN = 4'd3,
    ST_INC  = 4'd4,
    ST_DEC  = 4'd5,
    ST_WR   = 4'd6,
    ST_NEXT = 4'd7,
    ST_FIN  = 4'd8
  } tally_state_e;

endpackage

// File: rtl/sgn_tally_ctrl.sv
module sgn_tally_ctrl
  import sgn_tally_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic idx_at_end,
  input  logic word_pos,
  output logic clr_run,
  output logic rd_evt,
  output logic wr_evt,
  output logic inc_evt,
  output logic dec_evt,
  output logic idx_step,
  output logic done
);

  tally_state_e state_q, state_d;
  logic         accept;

  assign accept   = start && (state_q == ST_IDLE || state_q == ST_FIN);
  assign clr_run  = accept;
  assign rd_evt   = (state_q == ST_RD);
  assign wr_evt   = (state_q == ST_WR);
  assign inc_evt  = (state_q == ST_INC);
  assign dec_evt  = (state_q == ST_DEC);
  assign idx_step = (state_q == ST_NEXT);
  assign done     = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_CMP;
      ST_FIN:  if (accept) state_d = ST_CMP;
      ST_CMP:  state_d = idx_at_end ? ST_FIN : ST_RD;
      ST_RD:   state_d = ST_SIGN;
      ST_SIGN: state_d = word_pos ? ST_INC : ST_DEC;
      ST_INC:  state_d = ST_WR;
      ST_DEC:  state_d = ST_WR;
      ST_WR:   state_d = ST_NEXT;
      ST_NEXT: state_d = ST_CMP;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R6: completion is held until a new start arrives
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R9: a start seen mid-run does not restart the walk
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && (state_q == ST_RD) |=> state_q == ST_SIGN);

endmodule

// File: rtl/sgn_tally_dp.sv
module sgn_tally_dp #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int ELEMS  = 100,
  localparam int IDX_W = $clog2(ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              clr_run,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic              inc_evt,
  input  logic              dec_evt,
  input  logic              idx_step,
  output logic              idx_at_end,
  output logic              word_pos,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] count_out
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ELEMS);

  function automatic logic is_positive(input logic [DATA_W-1:0] w);
    return !w[DATA_W-1] && (|w);
  endfunction

  function automatic logic [DATA_W-1:0] step_count(input logic [DATA_W-1:0] c,
                                                   input logic up);
    return up ? c + DATA_W'(1) : c - DATA_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0] i);
    return b + ADDR_W'(i);
  endfunction

  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] cnt_q;
  logic [ADDR_W-1:0] rd_addr_q;

  assign idx_at_end = (idx_q == LAST_IDX);
  assign word_pos   = is_positive(mem_rdata);
  assign mem_addr   = elem_addr(base_q, idx_q);
  assign mem_wdata  = cnt_q;
  assign count_out  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      idx_q     <= '0;
      cnt_q     <= '0;
      rd_addr_q <= '0;
    end else begin
      if (clr_run) begin
        base_q <= base_addr;
        idx_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (idx_step) idx_q <= idx_q + IDX_W'(1);
        if (inc_evt || dec_evt) cnt_q <= step_count(cnt_q, inc_evt);
      end
      if (rd_evt) rd_addr_q <= mem_addr;
    end
  end

  // R2: an accepted start zeroes count and index
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_run |=> (cnt_q == '0) && (idx_q == '0));

  // R4: up step on a positive word, down step otherwise
  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> cnt_q == $past(cnt_q) + DATA_W'(1));
  assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> cnt_q == $past(cnt_q) - DATA_W'(1));

  // R5: writeback targets the location that was read
  assert_wr_same_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> mem_addr == rd_addr_q);

  // R3: the index never runs past the array length
  assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/sgn_tally_walker.sv
module sgn_tally_walker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int ELEMS  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  logic clr_run, rd_evt, wr_evt, inc_evt, dec_evt, idx_step;
  logic idx_at_end, word_pos;

  sgn_tally_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .idx_at_end (idx_at_end),
    .word_pos   (word_pos),
    .clr_run    (clr_run),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .inc_evt    (inc_evt),
    .dec_evt    (dec_evt),
    .idx_step   (idx_step),
    .done       (done)
  );

  sgn_tally_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .ELEMS  (ELEMS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_addr  (base_addr),
    .mem_rdata  (mem_rdata),
    .clr_run    (clr_run),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .inc_evt    (inc_evt),
    .dec_evt    (dec_evt),
    .idx_step   (idx_step),
    .idx_at_end (idx_at_end),
    .word_pos   (word_pos),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .count_out  (result)
  );

  assign mem_rd = rd_evt;
  assign mem_wr = wr_evt;

  // R7: read and write strobes are exclusive at the block edge
  assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

// File: tb/sgn_tally_walker_tb_top.sv
`timescale 1ns/1ps
module sgn_tally_walker_tb_top;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam int N  = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_rdata = '0;
  logic [DW-1:0] mem_wdata, result;
  logic          done;

  always #2 clk = ~clk;

  sgn_tally_walker #(.DATA_W(DW), .ADDR_W(AW), .ELEMS(N)) dut_i (.*);

  int total = 0;
  int fails = 0;

  logic [DW-1:0] arr [N];
  logic [DW-1:0] exp_cnt [N];
  logic [DW-1:0] exp_final;
  logic [AW-1:0] run_base;
  int rd_n, wr_n, bad_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench memory: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd || mem_wr) begin
      automatic logic [AW-1:0] off = mem_addr - run_base;
      if (off >= AW'(N)) bad_addr++;
      else if (mem_rd) mem_rdata <= arr[off];
      else arr[off] <= mem_wdata;
    end
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) chk(1'b0, "R7", "rd and wr together", 1, 0);
      if (mem_rd) begin
        if (rd_n < N)
          chk(mem_addr == run_base + AW'(rd_n), "R3", "read address", mem_addr,
              run_base + AW'(rd_n));
        rd_n++;
      end
      if (mem_wr) begin
        if (wr_n < N) begin
          chk(mem_addr == run_base + AW'(wr_n), "R5", "write address", mem_addr,
              run_base + AW'(wr_n));
          chk(mem_wdata == exp_cnt[wr_n], "R5", "write data", mem_wdata, exp_cnt[wr_n]);
        end
        wr_n++;
      end
    end
  end

  task automatic model();
    logic [DW-1:0] c = '0;
    for (int i = 0; i < N; i++) begin
      if ($signed(arr[i]) > 0) c = c + 1'b1;
      else c = c - 1'b1;
      exp_cnt[i] = c;
    end
    exp_final = c;
  endtask

  task automatic run(input logic [AW-1:0] base, input bit extra_start, input string tag);
    int cyc = 0;
    model();
    rd_n = 0; wr_n = 0; bad_addr = 0;
    @(negedge clk);
    run_base  = base;
    base_addr = base;
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    base_addr = ~base;
    // R2: accepted start clears the count
    chk(result == '0, "R2", {tag, " count cleared"}, result, 0);
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = extra_start && (cyc == 50 || cyc == 333);
    end
    start = 1'b0;
    chk(cyc == 6*N+1, extra_start ? "R9" : "R8", {tag, " latency"}, cyc, 6*N+1);
    chk(result == exp_final, "R6", {tag, " final result"}, result, exp_final);
    chk(rd_n == N, "R3", {tag, " read count"}, rd_n, N);
    chk(wr_n == N, "R5", {tag, " write count"}, wr_n, N);
    chk(bad_addr == 0, "R3", {tag, " out-of-array access"}, bad_addr, 0);
    for (int i = 0; i < N; i++)
      if (arr[i] !== exp_cnt[i]) chk(1'b0, "R4", {tag, " stored word"}, arr[i], exp_cnt[i]);
    chk(1'b1, "R4", {tag, " stored words"}, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R1", "strobes after reset", {mem_rd, mem_wr}, 0);
    chk(result == '0, "R1", "result after reset", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // random mix
    for (int i = 0; i < N; i++) arr[i] = DW'($urandom);
    run(AW'($urandom), 1'b0, "random");

    // R4: all zero words decrement
    for (int i = 0; i < N; i++) arr[i] = '0;
    run(16'h0100, 1'b0, "zeros");
    chk(result == 16'hFF9C, "R4", "zeros give -N", result, 16'hFF9C);

    // R4 extremes, array straddling address wrap (R3)
    for (int i = 0; i < N; i++) begin
      case (i % 5)
        0: arr[i] = 16'h7FFF;
        1: arr[i] = 16'h8000;
        2: arr[i] = 16'h0001;
        3: arr[i] = 16'hFFFF;
        default: arr[i] = 16'h0000;
      endcase
    end
    run(16'hFFC0, 1'b0, "extremes");

    // R9: all positive, extra start pulses mid-run
    for (int i = 0; i < N; i++) arr[i] = 16'h0001 + DW'($urandom_range(0, 16'h7FFE));
    run(AW'($urandom), 1'b1, "busy-start");
    chk(result == DW'(N), "R4", "all positive give +N", result, N);

    // R6: done holds without start
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R6", "done held", done, 1);
    chk(result == DW'(N), "R6", "result held", result, N);

    // R2: rerun on the rewritten array restarts from zero
    for (int i = 0; i < 7; i++) arr[$urandom_range(0, N-1)] = DW'($urandom);
    run(run_base, 1'b0, "rerun");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule